// File: doc/BRIEF.md
# Camera Receiver PHY Control Register Bank

This block is a small bank of 32-bit control registers for a camera receive PHY, reached over a simple single-cycle memory-mapped bus. A write carries its own per-bit enable: the upper half-word of the write data is a mask, and the lower half-word is the new data. Only the stored bits whose mask bit is 1 take the new value. All other bits keep their old value. Software can therefore change one field without first reading the register back.

The bank has four control registers and one read-only status register. The control registers hold these fields:
- per-lane receive enables;
- forced receive and forced stop modes for the receive and transmit ports;
- turnaround disables and turnaround requests;
- two clock-invert selects;
- a test port: data in, enable, clock and clear.

Every field is driven straight out as its own port. The status register returns an 8-bit test readback value taken from an input.

A two-state access machine controls read responses. In `ACC_IDLE` no read data is being returned. A read request moves it to `ACC_READ`. A read request in either state leads to `ACC_READ` on the next cycle, and any other cycle leads back to `ACC_IDLE`. In `ACC_READ` the output `rd_valid` is 1 and `rd_data` holds the word captured on the edge where the request was accepted. Writes update the registers on the edge where they are accepted, whatever the state.

Top module: `phy_ctl_regbank`

## Requirements
- R1: On synchronous active-high reset, every control register and every field output becomes 0, and `rd_valid` and `rd_data` become 0.
- R2: On an accepted write to a control register, stored bit n (0..15) becomes write-data bit n when write-data bit n+16 is 1, and keeps its old value otherwise. A write with an all-zero mask changes nothing.
- R3: The register at byte offset 0x6254 drives these outputs: `rx_lane_en` from bits [3:0], `rx_force_rx` from [7:4], `rx_force_stop` from [11:8] and `rx_turn_dis` from [15:12].
- R4: The register at offset 0x6258 drives these outputs: `tx_force_rx` from [3:0], `tx_force_stop` from [7:4], `tx_turn_dis` from [11:8] and `tx_turn_req` from [15:12].
- R5: The register at offset 0x6260 drives these outputs: `tst_din` from [7:0], `tst_en` from bit 8, `tst_clk` from bit 9 and `tst_clr` from bit 10.
- R6: The register at offset 0x6224 drives these outputs: `rx_turn_req` from [3:0], `rx_clk_inv_p0` from bit 10 and `rx_clk_inv_p1` from bit 11.
- R7: A read of a control register returns the full stored 16-bit half-word in `rd_data[15:0]`, with `rd_data[31:16]` equal to 0.
- R8: A read of offset 0xE2A4 returns the `tst_dout` value present at the request in `rd_data[7:0]`, with all other bits 0. Writes to 0xE2A4 change no register.
- R9: Writes to any offset other than the five listed are ignored. Reads of such offsets return 0.
- R10: `rd_valid` is 1 in exactly the cycle after each accepted read request and 0 in every other cycle. A write never raises it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A bus request is present this cycle |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_addr | input | ADDR_W | Byte offset of the access |
| req_wdata | input | DATA_W | Write data: mask in the upper half, data in the lower half |
| tst_dout | input | 8 | Test readback value from the PHY |
| rd_valid | output | 1 | Read data is valid this cycle |
| rd_data | output | DATA_W | Read data |
| rx_lane_en | output | 4 | Receive lane enables |
| rx_force_rx | output | 4 | Receive port forced receive mode |
| rx_force_stop | output | 4 | Receive port forced stop mode |
| rx_turn_dis | output | 4 | Receive port turnaround disable |
| tx_force_rx | output | 4 | Transmit port forced receive mode |
| tx_force_stop | output | 4 | Transmit port forced stop mode |
| tx_turn_dis | output | 4 | Transmit port turnaround disable |
| tx_turn_req | output | 4 | Transmit port turnaround request |
| tst_din | output | 8 | Test port data in |
| tst_en | output | 1 | Test port enable |
| tst_clk | output | 1 | Test port clock level |
| tst_clr | output | 1 | Test port clear |
| rx_turn_req | output | 4 | Receive port turnaround request |
| rx_clk_inv_p0 | output | 1 | Clock-invert select, first receiver |
| rx_clk_inv_p1 | output | 1 | Clock-invert select, second receiver |

## Verification
A write accepted on clock edge k shows on the field outputs right after edge k. A read accepted on edge k gives `rd_valid` and `rd_data` right after edge k, and they hold for that one cycle. The bench keeps a behavioural model that is updated on the same edge as the design. It drives the bus and compares every output on the falling edge, half a period after the edge where both the design and the model were updated. The directed checks read the result on the falling edge that follows the write or read they test.

// File: rtl/phy_ctl_pkg.sv
package phy_ctl_pkg;

    // Control register slots, fixed by the address map
    localparam int NUM_CTL  = 4;
    localparam int IDX_TURN = 0;
    localparam int IDX_RX   = 1;
    localparam int IDX_TX   = 2;
    localparam int IDX_TST  = 3;

    localparam logic [15:0] OFS_TURN = 16'h6224;
    localparam logic [15:0] OFS_RX   = 16'h6254;
    localparam logic [15:0] OFS_TX   = 16'h6258;
    localparam logic [15:0] OFS_TST  = 16'h6260;
    localparam logic [15:0] OFS_STAT = 16'hE2A4;

    localparam logic [15:0] CTL_OFS [NUM_CTL] = '{OFS_TURN, OFS_RX, OFS_TX, OFS_TST};

    localparam int TST_DOUT_W = 8;

    typedef enum logic [0:0] {
        ACC_IDLE = 1'b0,
        ACC_READ = 1'b1
    } acc_state_e;

endpackage

// File: rtl/regbank_decode.sv
module regbank_decode
    import phy_ctl_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic [ADDR_W-1:0]  addr,
    output logic [NUM_CTL-1:0] ctl_hit,
    output logic               stat_hit
);

    for (genvar g = 0; g < NUM_CTL; g++) begin : g_hit
        assign ctl_hit[g] = (addr == ADDR_W'(CTL_OFS[g]));
    end

    assign stat_hit = (addr == ADDR_W'(OFS_STAT));

endmodule

// File: rtl/masked_reg.sv
module masked_reg #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_mask,
    input  logic [WIDTH-1:0] wr_data,
    output logic [WIDTH-1:0] q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (wr_en) begin
            q <= (q & ~wr_mask) | (wr_data & wr_mask);
        end
    end

endmodule

// File: rtl/phy_ctl_regbank.sv
module phy_ctl_regbank
    import phy_ctl_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [7:0]        tst_dout,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic [3:0]        rx_lane_en,
    output logic [3:0]        rx_force_rx,
    output logic [3:0]        rx_force_stop,
    output logic [3:0]        rx_turn_dis,
    output logic [3:0]        tx_force_rx,
    output logic [3:0]        tx_force_stop,
    output logic [3:0]        tx_turn_dis,
    output logic [3:0]        tx_turn_req,
    output logic [7:0]        tst_din,
    output logic              tst_en,
    output logic              tst_clk,
    output logic              tst_clr,
    output logic [3:0]        rx_turn_req,
    output logic              rx_clk_inv_p0,
    output logic              rx_clk_inv_p1
);

    localparam int HALF_W = DATA_W / 2;

    logic [NUM_CTL-1:0] ctl_hit;
    logic               stat_hit;
    logic               wr_req;
    logic               rd_req;
    logic [HALF_W-1:0]  ctl_q [NUM_CTL];
    logic [DATA_W-1:0]  rd_next;
    logic [DATA_W-1:0]  rd_data_q;
    acc_state_e         state_q;
    acc_state_e         state_d;

    assign wr_req = req_valid &&  req_write;
    assign rd_req = req_valid && !req_write;

    regbank_decode #(.ADDR_W(ADDR_W)) u_decode (
        .addr     (req_addr),
        .ctl_hit  (ctl_hit),
        .stat_hit (stat_hit)
    );

    for (genvar g = 0; g < NUM_CTL; g++) begin : g_ctl
        masked_reg #(.WIDTH(HALF_W)) u_reg (
            .clk     (clk),
            .rst     (rst),
            .wr_en   (wr_req && ctl_hit[g]),
            .wr_mask (req_wdata[DATA_W-1:HALF_W]),
            .wr_data (req_wdata[HALF_W-1:0]),
            .q       (ctl_q[g])
        );
    end

    // Read word selection; unmapped offsets fall through to zero
    always_comb begin
        rd_next = '0;
        for (int i = 0; i < NUM_CTL; i++) begin
            if (ctl_hit[i]) begin
                rd_next[HALF_W-1:0] = ctl_q[i];
            end
        end
        if (stat_hit) begin
            rd_next[TST_DOUT_W-1:0] = tst_dout;
        end
    end

    // Access state machine: next state
    always_comb begin
        unique case (state_q)
            ACC_IDLE: state_d = rd_req ? ACC_READ : ACC_IDLE;
            ACC_READ: state_d = rd_req ? ACC_READ : ACC_IDLE;
            default:  state_d = ACC_IDLE;
        endcase
    end

    // Access state machine: state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ACC_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Access state machine: outputs
    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data_q <= '0;
        end else if (rd_req) begin
            rd_data_q <= rd_next;
        end
    end

    assign rd_valid = (state_q == ACC_READ);
    assign rd_data  = rd_data_q;

    // Field outputs
    assign rx_lane_en    = ctl_q[IDX_RX][3:0];
    assign rx_force_rx   = ctl_q[IDX_RX][7:4];
    assign rx_force_stop = ctl_q[IDX_RX][11:8];
    assign rx_turn_dis   = ctl_q[IDX_RX][15:12];

    assign tx_force_rx   = ctl_q[IDX_TX][3:0];
    assign tx_force_stop = ctl_q[IDX_TX][7:4];
    assign tx_turn_dis   = ctl_q[IDX_TX][11:8];
    assign tx_turn_req   = ctl_q[IDX_TX][15:12];

    assign tst_din       = ctl_q[IDX_TST][7:0];
    assign tst_en        = ctl_q[IDX_TST][8];
    assign tst_clk       = ctl_q[IDX_TST][9];
    assign tst_clr       = ctl_q[IDX_TST][10];

    assign rx_turn_req   = ctl_q[IDX_TURN][3:0];
    assign rx_clk_inv_p0 = ctl_q[IDX_TURN][10];
    assign rx_clk_inv_p1 = ctl_q[IDX_TURN][11];

endmodule

// File: rtl/phy_ctl_regbank_chk.sv
module phy_ctl_regbank_chk
    import phy_ctl_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_write,
    input logic [ADDR_W-1:0] req_addr,
    input logic [DATA_W-1:0] req_wdata,
    input logic [7:0]        tst_dout,
    input logic              rd_valid,
    input logic [DATA_W-1:0] rd_data,
    input logic [15:0]       rx_word
);

    localparam int HALF_W = DATA_W / 2;

    logic rd_req;
    logic wr_rx;
    logic mapped;

    assign rd_req = req_valid && !req_write;
    assign wr_rx  = req_valid && req_write && (req_addr == ADDR_W'(OFS_RX));
    assign mapped = (req_addr == ADDR_W'(OFS_TURN)) || (req_addr == ADDR_W'(OFS_RX))
                 || (req_addr == ADDR_W'(OFS_TX))   || (req_addr == ADDR_W'(OFS_TST))
                 || (req_addr == ADDR_W'(OFS_STAT));

    p_rd_follows_req_r10: assert property (@(posedge clk) disable iff (rst)
        rd_req |=> rd_valid);

    p_no_spurious_rd_r10: assert property (@(posedge clk) disable iff (rst)
        !rd_req |=> !rd_valid);

    p_upper_zero_r7: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> (rd_data[DATA_W-1:HALF_W] == '0));

    p_zero_mask_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (wr_rx && req_wdata[DATA_W-1:HALF_W] == '0) |=> $stable(rx_word));

    p_full_mask_load_r2: assert property (@(posedge clk) disable iff (rst)
        (wr_rx && (&req_wdata[DATA_W-1:HALF_W])) |=> (rx_word == $past(req_wdata[15:0])));

    p_status_read_r8: assert property (@(posedge clk) disable iff (rst)
        (rd_req && req_addr == ADDR_W'(OFS_STAT)) |=> (rd_data == DATA_W'($past(tst_dout))));

    p_unmapped_read_r9: assert property (@(posedge clk) disable iff (rst)
        (rd_req && !mapped) |=> (rd_data == '0));

endmodule

bind phy_ctl_regbank phy_ctl_regbank_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .tst_dout  (tst_dout),
    .rd_valid  (rd_valid),
    .rd_data   (rd_data),
    .rx_word   ({rx_turn_dis, rx_force_stop, rx_force_rx, rx_lane_en})
);

// File: tb/phy_ctl_regbank_tb.sv
module phy_ctl_regbank_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [15:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic [7:0]  tst_dout = '0;
    logic        rd_valid;
    logic [31:0] rd_data;
    logic [3:0]  rx_lane_en, rx_force_rx, rx_force_stop, rx_turn_dis;
    logic [3:0]  tx_force_rx, tx_force_stop, tx_turn_dis, tx_turn_req;
    logic [7:0]  tst_din;
    logic        tst_en, tst_clk, tst_clr;
    logic [3:0]  rx_turn_req;
    logic        rx_clk_inv_p0, rx_clk_inv_p1;

    always #5 clk = ~clk;

    phy_ctl_regbank u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .tst_dout(tst_dout),
        .rd_valid(rd_valid), .rd_data(rd_data),
        .rx_lane_en(rx_lane_en), .rx_force_rx(rx_force_rx),
        .rx_force_stop(rx_force_stop), .rx_turn_dis(rx_turn_dis),
        .tx_force_rx(tx_force_rx), .tx_force_stop(tx_force_stop),
        .tx_turn_dis(tx_turn_dis), .tx_turn_req(tx_turn_req),
        .tst_din(tst_din), .tst_en(tst_en), .tst_clk(tst_clk), .tst_clr(tst_clr),
        .rx_turn_req(rx_turn_req), .rx_clk_inv_p0(rx_clk_inv_p0),
        .rx_clk_inv_p1(rx_clk_inv_p1)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit running = 0;
    bit done = 0;

    // Reference model state: 0=0x6224, 1=0x6254, 2=0x6258, 3=0x6260
    logic [15:0] m_ctl [4];
    logic        e_rv;
    logic [31:0] e_rd;
    string       e_tag;

    function automatic int slot_of(logic [15:0] a);
        case (a)
            16'h6224: return 0;
            16'h6254: return 1;
            16'h6258: return 2;
            16'h6260: return 3;
            16'hE2A4: return 4;
            default:  return -1;
        endcase
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 4; i++) m_ctl[i] <= '0;
            e_rv  <= 1'b0;
            e_rd  <= '0;
            e_tag <= "R1";
        end else begin
            e_rv <= req_valid && !req_write;
            if (req_valid && !req_write) begin
                if (slot_of(req_addr) >= 0 && slot_of(req_addr) < 4) begin
                    e_rd  <= {16'h0, m_ctl[slot_of(req_addr)]};
                    e_tag <= "R7";
                end else if (slot_of(req_addr) == 4) begin
                    e_rd  <= {24'h0, tst_dout};
                    e_tag <= "R8";
                end else begin
                    e_rd  <= '0;
                    e_tag <= "R9";
                end
            end
            if (req_valid && req_write && slot_of(req_addr) >= 0 && slot_of(req_addr) < 4) begin
                m_ctl[slot_of(req_addr)] <= (m_ctl[slot_of(req_addr)] & ~req_wdata[31:16])
                                          | (req_wdata[15:0] & req_wdata[31:16]);
            end
        end
    end

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // Every-cycle comparison against the model, half a period after the edge
    always @(negedge clk) begin
        if (running) begin
            chk("R10 rd_valid", 32'(rd_valid), 32'(e_rv));
            chk({e_tag, " rd_data"}, rd_data, e_rd);
            chk("R3 rx fields", 32'({rx_turn_dis, rx_force_stop, rx_force_rx, rx_lane_en}),
                32'(m_ctl[1]));
            chk("R4 tx fields", 32'({tx_turn_req, tx_turn_dis, tx_force_stop, tx_force_rx}),
                32'(m_ctl[2]));
            chk("R5 test fields", 32'({tst_clr, tst_clk, tst_en, tst_din}),
                32'(m_ctl[3][10:0]));
            chk("R6 turn/clkinv", 32'({rx_clk_inv_p1, rx_clk_inv_p0, rx_turn_req}),
                32'({m_ctl[0][11:10], m_ctl[0][3:0]}));
        end
    end

    task automatic bus(bit v, bit w, logic [15:0] a, logic [31:0] d);
        @(negedge clk);
        req_valid = v;
        req_write = w;
        req_addr  = a;
        req_wdata = d;
    endtask

    task automatic idle();
        bus(1'b0, 1'b0, 16'h0, 32'h0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        #1_000_000;
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [15:0] addrs [8];
        addrs = '{16'h6224, 16'h6254, 16'h6258, 16'h6260, 16'hE2A4, 16'h6228, 16'h0000, 16'hFFFC};
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        running = 1;
        // R1: reset values at the ports
        chk("R1 reset rx", 32'({rx_turn_dis, rx_force_stop, rx_force_rx, rx_lane_en}), 32'h0);
        chk("R1 reset rd_valid", 32'(rd_valid), 32'h0);

        // R2: full mask, then partial mask clearing one nibble
        bus(1, 1, 16'h6254, 32'hFFFF_A5C3);
        bus(1, 1, 16'h6254, 32'h00F0_0000);
        idle();
        chk("R2 partial mask", 32'({rx_turn_dis, rx_force_stop, rx_force_rx, rx_lane_en}), 32'hA503);
        // R2: zero mask changes nothing
        bus(1, 1, 16'h6254, 32'h0000_FFFF);
        idle();
        chk("R2 zero mask", 32'({rx_turn_dis, rx_force_stop, rx_force_rx, rx_lane_en}), 32'hA503);

        // R4, R5, R6 field writes and R7 readbacks
        bus(1, 1, 16'h6258, 32'hFFFF_1234);
        bus(1, 1, 16'h6260, 32'hFFFF_FFFF);
        bus(1, 1, 16'h6224, 32'hFFFF_0C05);
        bus(1, 0, 16'h6260, 32'h0);
        idle();
        chk("R7 test reg read", rd_data, 32'h0000_FFFF);
        bus(1, 0, 16'h6258, 32'h0);

        // R8: status write ignored, read returns tst_dout
        tst_dout = 8'h5A;
        bus(1, 1, 16'hE2A4, 32'hFFFF_FFFF);
        bus(1, 0, 16'hE2A4, 32'h0);
        idle();
        chk("R8 status read", rd_data, 32'h0000_005A);

        // R9: unmapped write ignored, read returns zero
        bus(1, 1, 16'h6228, 32'hFFFF_FFFF);
        bus(1, 0, 16'h6228, 32'h0);
        idle();
        chk("R9 unmapped read", rd_data, 32'h0);

        // Back-to-back reads keep rd_valid high (R10)
        bus(1, 0, 16'h6254, 32'h0);
        bus(1, 0, 16'h6224, 32'h0);
        idle();

        // Random traffic across mapped, status and unmapped offsets
        for (int i = 0; i < 600; i++) begin
            tst_dout = 8'($urandom);
            bus(($urandom % 4) != 0, ($urandom % 2) == 0, addrs[$urandom % 8], $urandom);
        end

        // R1: reset in the middle of traffic
        bus(1, 1, 16'h6258, 32'hFFFF_FFFF);
        @(negedge clk);
        rst = 1'b1;
        req_valid = 1'b0;
        @(negedge clk);
        rst = 1'b0;
        chk("R1 mid reset tx", 32'({tx_turn_req, tx_turn_dis, tx_force_stop, tx_force_rx}), 32'h0);
        repeat (4) idle();
        finish_run();
    end

endmodule